// File: doc/BRIEF.md
# Multiplexed LCD Row-Scan Controller

This block drives the scan of a dot-matrix LCD. Each row lasts a fixed number of enable ticks. A one-hot row strobe walks from row 0 up to the last row that the selected multiplex ratio allows, and then starts over. For the active row, the block forms a display-RAM address, reads that row's word through an external read port, and puts the word on the column outputs after applying the display mode.

Four ratios are available: 8, 16, 24 or 32 rows per frame. RAM is organised as banks of eight rows. A start-bank value chooses which bank appears on the top line of the panel, and the rows below it follow in wrapped order, which gives cheap scrolling. The display mode can blank the columns, show the data as stored, force every dot on, or show the complement of the data.

Ratio, start bank and mode are taken into use only when a new frame begins, so no frame ever shows a mix of old and new settings. A single-cycle frame marker accompanies the first cycle of row 0 of every frame.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: The ratio code `mux_sel` gives (code+1)*8 rows per frame: 00 = 8, 01 = 16, 10 = 24, 11 = 32. The active row index counts 0, 1, ... up to that count minus one and then returns to 0.
- R2: Exactly one bit of `row_sel` is high at any time, bit i for row i. No bit at or above the active row count is ever high.
- R3: `ram_raddr` equals (start_bank*8 + row) modulo 32, where start_bank is the active bank value.
- R4: Display-mode code: 00 drives all columns low; 01 drives the RAM word unchanged; 10 drives all columns high; 11 drives the bitwise complement of the RAM word.
- R5: After reset, row 0 is selected, `frame_sync` is low, and the active settings are ratio 8, bank 0 and mode blank. The columns stay low until the first frame boundary.
- R6: Each row is held for HOLD_TICKS cycles in which `tick_en` is high. While `tick_en` is low, the row select does not move.
- R7: `frame_sync` is high for exactly one cycle: the first cycle of row 0 of every frame that starts after reset.
- R8: Changes on `mux_sel`, `bank_sel` and `disp_mode` become active only at the move from the last row to row 0. A change made mid-frame does not alter the rest of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Row-timing enable tick |
| mux_sel | input | 2 | Requested multiplex ratio code |
| bank_sel | input | 2 | Requested top-of-screen bank |
| disp_mode | input | 2 | Requested display mode code |
| ram_rdata | input | 40 | Display RAM word for `ram_raddr` (combinational read) |
| ram_raddr | output | 5 | Display RAM row address |
| row_sel | output | 32 | One-hot row strobe |
| col_data | output | 40 | Column data after the mode is applied |
| frame_sync | output | 1 | Start-of-frame marker |

## Verification
The hardest case to reach from the ports is a settings change that lands in the middle of a frame: the rest of that frame must stay on the old ratio, bank and mode, and only the next frame may switch. To reach it, the stimulus synchronises on `frame_sync`, waits two full rows, and then writes a new ratio, bank and mode all at once. It then checks every remaining row against the old settings, and checks the following frame's length, addresses and column polarity against the new ones. A bank-3 setting at the 32-row ratio forces the address to wrap past the end of RAM.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    typedef enum logic [1:0] {
        MODE_BLANK   = 2'b00,
        MODE_NORMAL  = 2'b01,
        MODE_ALL_ON  = 2'b10,
        MODE_INVERSE = 2'b11
    } disp_mode_e;

    localparam int unsigned MUX_W  = 2;
    localparam int unsigned MODE_W = 2;

endpackage

// File: rtl/lcd_row_timer.sv
module lcd_row_timer #(
    parameter int unsigned HOLD_TICKS = 4,
    parameter int unsigned ROW_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [ROW_W-1:0] last_row,
    output logic [ROW_W-1:0] row_idx,
    output logic             frame_edge,
    output logic             frame_sync
);

    localparam int unsigned CNT_W = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_TICKS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [ROW_W-1:0] row;
        logic             sync;
    } timer_st_t;

    timer_st_t st_d, st_q;
    logic      edge_d;

    always_comb begin
        st_d      = st_q;
        st_d.sync = 1'b0;
        edge_d    = 1'b0;
        if (tick_en) begin
            if (st_q.cnt == CNT_LAST) begin
                st_d.cnt = '0;
                if (st_q.row == last_row) begin
                    st_d.row  = '0;
                    st_d.sync = 1'b1;
                    edge_d    = 1'b1;
                end else begin
                    st_d.row = st_q.row + 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign row_idx    = st_q.row;
    assign frame_edge = edge_d;
    assign frame_sync = st_q.sync;

endmodule

// File: rtl/lcd_cfg_shadow.sv
module lcd_cfg_shadow #(
    parameter int unsigned CFG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CFG_W-1:0] cfg_in,
    output logic [CFG_W-1:0] cfg_act
);

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
    } shadow_st_t;

    shadow_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cfg = cfg_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_act = st_q.cfg;

endmodule

// File: rtl/lcd_col_shaper.sv
module lcd_col_shaper
    import lcd_scan_pkg::*;
#(
    parameter int unsigned COLS = 40
) (
    input  disp_mode_e      mode,
    input  logic [COLS-1:0] raw,
    output logic [COLS-1:0] cols
);

    always_comb begin
        unique case (mode)
            MODE_BLANK:   cols = '0;
            MODE_NORMAL:  cols = raw;
            MODE_ALL_ON:  cols = '1;
            MODE_INVERSE: cols = ~raw;
            default:      cols = '0;
        endcase
    end

endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
    import lcd_scan_pkg::*;
#(
    parameter int unsigned ROWS_PER_BANK = 8,
    parameter int unsigned NUM_BANKS     = 4,
    parameter int unsigned COLS          = 40,
    parameter int unsigned HOLD_TICKS    = 4,
    localparam int unsigned MAX_ROWS     = ROWS_PER_BANK * NUM_BANKS,
    localparam int unsigned ROW_W        = $clog2(MAX_ROWS),
    localparam int unsigned BANK_W       = $clog2(NUM_BANKS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic [MUX_W-1:0]    mux_sel,
    input  logic [BANK_W-1:0]   bank_sel,
    input  logic [MODE_W-1:0]   disp_mode,
    input  logic [COLS-1:0]     ram_rdata,
    output logic [ROW_W-1:0]    ram_raddr,
    output logic [MAX_ROWS-1:0] row_sel,
    output logic [COLS-1:0]     col_data,
    output logic                frame_sync
);

    localparam int unsigned CFG_W = MUX_W + BANK_W + MODE_W;

    logic [ROW_W-1:0]  row_idx;
    logic [ROW_W-1:0]  last_row;
    logic              frame_edge;
    logic [CFG_W-1:0]  cfg_act;
    logic [MUX_W-1:0]  act_mux;
    logic [BANK_W-1:0] act_bank;
    logic [MODE_W-1:0] act_mode;

    assign {act_mux, act_bank, act_mode} = cfg_act;
    assign last_row = ROW_W'((int'(act_mux) + 1) * ROWS_PER_BANK - 1);

    lcd_row_timer #(
        .HOLD_TICKS (HOLD_TICKS),
        .ROW_W      (ROW_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .last_row   (last_row),
        .row_idx    (row_idx),
        .frame_edge (frame_edge),
        .frame_sync (frame_sync)
    );

    lcd_cfg_shadow #(
        .CFG_W (CFG_W)
    ) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (frame_edge),
        .cfg_in  ({mux_sel, bank_sel, disp_mode}),
        .cfg_act (cfg_act)
    );

    assign ram_raddr = ROW_W'(int'(act_bank) * ROWS_PER_BANK) + row_idx;

    lcd_col_shaper #(
        .COLS (COLS)
    ) u_shaper (
        .mode (disp_mode_e'(act_mode)),
        .raw  (ram_rdata),
        .cols (col_data)
    );

    for (genvar gi = 0; gi < MAX_ROWS; gi++) begin : g_row_dec
        assign row_sel[gi] = (row_idx == ROW_W'(gi));
    end

endmodule

// File: rtl/lcd_scan_checks.sv
module lcd_scan_checks #(
    parameter int unsigned ROWS_PER_BANK = 8,
    parameter int unsigned MAX_ROWS      = 32,
    parameter int unsigned ROW_W         = 5,
    parameter int unsigned BANK_W        = 2,
    parameter int unsigned COLS          = 40
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick_en,
    input logic                frame_sync,
    input logic [MAX_ROWS-1:0] row_sel,
    input logic [ROW_W-1:0]    ram_raddr,
    input logic [COLS-1:0]     col_data,
    input logic [1:0]          act_mux,
    input logic [BANK_W-1:0]   act_bank,
    input logic [1:0]          act_mode
);

    logic [MAX_ROWS-1:0] allowed_rows;
    always_comb begin
        for (int i = 0; i < MAX_ROWS; i++) begin
            allowed_rows[i] = (i < (int'(act_mux) + 1) * ROWS_PER_BANK);
        end
    end

    p_one_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(row_sel) == 1);

    p_row_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (row_sel & ~allowed_rows) == '0);

    p_top_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        row_sel[0] |-> (ram_raddr == ROW_W'(int'(act_bank) * ROWS_PER_BANK)));

    p_blank_cols_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == 2'b00) |-> (col_data == '0));

    p_hold_still_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(row_sel));

    p_sync_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |-> row_sel[0]);

    p_sync_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> !frame_sync);

    p_cfg_at_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({act_mux, act_bank, act_mode}) |-> frame_sync);

endmodule

bind lcd_scan_ctrl lcd_scan_checks #(
    .ROWS_PER_BANK (ROWS_PER_BANK),
    .MAX_ROWS      (MAX_ROWS),
    .ROW_W         (ROW_W),
    .BANK_W        (BANK_W),
    .COLS          (COLS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .frame_sync (frame_sync),
    .row_sel    (row_sel),
    .ram_raddr  (ram_raddr),
    .col_data   (col_data),
    .act_mux    (act_mux),
    .act_bank   (act_bank),
    .act_mode   (act_mode)
);

// File: tb/sim_lcd_scan_ctrl.sv
`timescale 1ns/1ps
module sim_lcd_scan_ctrl;

    localparam int HOLD = 4;
    localparam int NV   = 6;
    // each vector: {mux, bank, mode}
    localparam logic [5:0] VEC [NV] = '{
        6'b11_00_01, 6'b01_10_11, 6'b00_01_10,
        6'b11_11_01, 6'b10_01_11, 6'b01_11_01
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [1:0]  mux_sel = 2'b00;
    logic [1:0]  bank_sel = 2'b00;
    logic [1:0]  disp_mode = 2'b00;
    logic [39:0] ram_rdata;
    logic [4:0]  ram_raddr;
    logic [31:0] row_sel;
    logic [39:0] col_data;
    logic        frame_sync;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    function automatic logic [39:0] ram_word(input logic [4:0] a);
        return {8{a}} ^ 40'h5AC3963CE1;
    endfunction

    function automatic logic [39:0] exp_cols(input logic [1:0] m, input logic [39:0] d);
        case (m)
            2'b00:   return '0;
            2'b01:   return d;
            2'b10:   return '1;
            default: return ~d;
        endcase
    endfunction

    assign ram_rdata = ram_word(ram_raddr);

    lcd_scan_ctrl u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .mux_sel    (mux_sel),
        .bank_sel   (bank_sel),
        .disp_mode  (disp_mode),
        .ram_rdata  (ram_rdata),
        .ram_raddr  (ram_raddr),
        .row_sel    (row_sel),
        .col_data   (col_data),
        .frame_sync (frame_sync)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_sync();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!frame_sync && n < 400);
        chk("R7 sync seen", 64'(frame_sync), 64'd1);
    endtask

    task automatic check_row(input int r, input logic [1:0] b, input logic [1:0] m);
        logic [4:0] a;
        a = 5'(int'(b) * 8 + r);
        chk("R1/R2 row_sel", 64'(row_sel), 64'(32'd1 << r));
        chk("R3 address", 64'(ram_raddr), 64'(a));
        chk("R4 columns", 64'(col_data), 64'(exp_cols(m, ram_word(a))));
    endtask

    initial begin
        logic [31:0] held;
        int n, len;
        repeat (3) @(negedge clk);
        disp_mode = 2'b01;
        mux_sel   = 2'b11;
        @(negedge clk);
        // R5: reset state
        chk("R5 row0", 64'(row_sel), 64'd1);
        chk("R5 sync low", 64'(frame_sync), 64'd0);
        chk("R5 blank", 64'(col_data), 64'd0);
        rst_n = 1'b1;
        tick_en = 1'b1;
        repeat (10) @(negedge clk);
        // R5/R8: first frame stays blank at 8 rows despite requested normal
        chk("R5 blank before boundary", 64'(col_data), 64'd0);
        chk("R8 old ratio row", 64'(row_sel), 64'(32'd1 << 2));

        // R6: no advance without ticks
        tick_en = 1'b0;
        held = row_sel;
        repeat (30) @(negedge clk);
        chk("R6 stalled", 64'(row_sel), 64'(held));
        tick_en = 1'b1;

        // vector table
        for (int v = 0; v < NV; v++) begin
            logic [1:0] vm, vb, vd;
            int nrows;
            {vm, vb, vd} = VEC[v];
            mux_sel = vm; bank_sel = vb; disp_mode = vd;
            nrows = (int'(vm) + 1) * 8;
            wait_sync();
            for (int r = 0; r < nrows; r++) begin
                check_row(r, vb, vd);
                repeat (HOLD) @(negedge clk);
            end
            chk("R1 wrap", 64'(row_sel), 64'd1);
            chk("R7 sync at wrap", 64'(frame_sync), 64'd1);
            @(negedge clk);
            chk("R7 sync one cycle", 64'(frame_sync), 64'd0);
        end

        // R6: row length with ticks every other cycle
        wait_sync();
        len = 0;
        tick_en = 1'b0;
        n = 0;
        while (row_sel[0] && n < 100) begin
            @(negedge clk);
            tick_en = ~tick_en;
            n++;
            len++;
        end
        chk("R6 row length half rate", 64'(len), 64'(2 * HOLD));
        tick_en = 1'b1;

        // R8: mid-frame change, current config is 16 rows, bank 3, normal
        wait_sync();
        repeat (2 * HOLD) @(negedge clk);
        mux_sel = 2'b00; bank_sel = 2'b00; disp_mode = 2'b11;
        for (int r = 2; r < 16; r++) begin
            check_row(r, 2'b11, 2'b01);
            repeat (HOLD) @(negedge clk);
        end
        chk("R8 new frame starts", 64'(frame_sync), 64'd1);
        for (int r = 0; r < 8; r++) begin
            check_row(r, 2'b00, 2'b11);
            repeat (HOLD) @(negedge clk);
        end
        chk("R8 new ratio wraps at 8", 64'(row_sel), 64'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule